// File: doc/BRIEF.md
# SHA-1 Block Compression Engine

This block performs the SHA-1 compression step on one 512-bit message block. A single-cycle `start` pulse captures a 160-bit chaining value and a 64-byte block. The engine then runs 80 rounds, one per clock, and adds the round result back into the captured chaining value. It reports the new 160-bit state with a one-cycle `done` pulse.

The message schedule is kept in a 16-word ring. The ring is loaded from the block at start. From round 16 on, each expanded word is written back over the oldest word in the ring. The round function and the additive constant change at rounds 20, 40 and 60.

To hash a message longer than one block, the caller feeds each result back as the next `state_in`. Padding, length encoding and splitting a message into blocks are left to the caller. Only whole 64-byte blocks are accepted.

Top module: `sha1_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `busy`, `done` and `state_out` are cleared to zero, and so is the round counter.
- R2: A `start` sampled high while idle captures the inputs and raises `busy` after that edge. `done` is high during the cycle that follows the 80th rising edge after the start edge, and at that edge `busy` falls.
- R3: Byte k of the block occupies `block_in[8k+7:8k]`. Message word i is formed with byte 4i as its most significant byte and byte 4i+3 as its least significant byte.
- R4: Working word A sits at bits [159:128] of `state_in` and `state_out`, then B, C and D in turn, with E at bits [31:0]. Each output word is the final working word plus the captured input word, modulo 2^32.
- R5: For rounds 16 to 79, the schedule word is the XOR of ring entries t, t-3, t-8 and t-14 (indices taken modulo 16), rotated left by one bit. The result replaces entry t mod 16.
- R6: Each round forms a new A as ROTL5(A) + f + E + K + W. The rounds are split into four groups:
  - rounds 0-19 use choose (B&(C^D))^D with K = 0x5A827999;
  - rounds 20-39 use parity B^C^D with K = 0x6ED9EBA1;
  - rounds 40-59 use majority ((B|C)&D)|(B&C) with K = 0x8F1BBCDC;
  - rounds 60-79 use parity with K = 0xCA62C1D6.
  
  The old A moves to B, ROTL30 of the old B moves to C, the old C moves to D and the old D moves to E.
- R7: `done` lasts exactly one cycle and is never high together with `busy`. `state_out` changes only at the edge that raises `done`, and otherwise holds its value.
- R8: A `start` sampled while `busy` is high is ignored. The running block completes with its own result, and no extra `done` follows.
- R9: Feeding `state_out` back as `state_in` chains blocks into a multi-block hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin compressing when idle |
| state_in | input | 160 | Chaining value A..E, A in the top word |
| block_in | input | 512 | 64 message bytes, byte k at bits [8k+7:8k] |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle pulse when `state_out` is new |
| state_out | output | 160 | Updated chaining value, held between blocks |

## Verification
The bench builds the engine with its default parameters: 80 rounds, groups of 20 and a 16-word ring. These are the only values that compute SHA-1, so every result can be compared with published digests and with a straightforward 80-word reference model kept in the bench. Those values make the single-block "abc" digest and a two-block chained digest directly reachable. Random blocks under random chaining values exercise all four round groups and the ring wrap-around. A second start issued partway through a block shows that the counter and result are unaffected.

// File: rtl/sha1_pkg.sv
// Shared types and helpers for the SHA-1 compression engine.
// Assumes 32-bit words; the working state is packed A (MSB) .. E (LSB).
package sha1_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } hstate_t;

    // Left rotate of one word by a fixed amount.
    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Additive constant selected by the 20-round group index.
    function automatic word_t grp_const(input logic [1:0] g);
        case (g)
            2'd0:    return 32'h5A827999;
            2'd1:    return 32'h6ED9EBA1;
            2'd2:    return 32'h8F1BBCDC;
            default: return 32'hCA62C1D6;
        endcase
    endfunction

    // Word-wise modulo-2^32 sum of two states.
    function automatic hstate_t add_state(input hstate_t x, input hstate_t y);
        hstate_t r;
        r.a = x.a + y.a;
        r.b = x.b + y.b;
        r.c = x.c + y.c;
        r.d = x.d + y.d;
        r.e = x.e + y.e;
        return r;
    endfunction

endpackage

// File: rtl/sha1_round.sv
// One combinational SHA-1 round: selects the group's boolean function and
// constant, forms the new A and shifts the remaining working words.
// Assumes grp is already decoded from the round index by the caller.
module sha1_round
    import sha1_pkg::*;
(
    input  hstate_t    cur,
    input  word_t      w,
    input  logic [1:0] grp,
    output hstate_t    nxt
);

    word_t f;

    // Boolean function of B, C, D for the current group.
    always_comb begin
        case (grp)
            2'd0:    f = (cur.b & (cur.c ^ cur.d)) ^ cur.d;
            2'd2:    f = ((cur.b | cur.c) & cur.d) | (cur.b & cur.c);
            default: f = cur.b ^ cur.c ^ cur.d;
        endcase
    end

    // New working words after this round.
    always_comb begin
        nxt.a = rotl(cur.a, 5) + f + cur.e + grp_const(grp) + w;
        nxt.b = cur.a;
        nxt.c = rotl(cur.b, 30);
        nxt.d = cur.c;
        nxt.e = cur.d;
    end

endmodule

// File: rtl/sha1_sched.sv
// Message schedule held in a DEPTH-word ring. On load, the block's bytes
// are regrouped into big-endian words. Rounds below DEPTH read the ring
// directly; later rounds expand in place from four taps.
// Assumes DEPTH is a power of two (16 for SHA-1) so indices wrap freely.
module sha1_sched
    import sha1_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int RND_W = 7,
    parameter int TAP_1 = 3,
    parameter int TAP_2 = 8,
    parameter int TAP_3 = 14
) (
    input  logic                    clk,
    input  logic                    load,
    input  logic                    step,
    input  logic [RND_W-1:0]        rnd,
    input  logic [DEPTH*WORD_W-1:0] block_in,
    output word_t                   w_out
);

    localparam int IDX_W = $clog2(DEPTH);

    word_t             ring [DEPTH];
    word_t             load_w [DEPTH];
    word_t             expanded;
    logic [IDX_W-1:0]  idx;
    logic              direct;

    // Regroup four little-position bytes into one big-endian word.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        assign load_w[gi] = {block_in[8*(4*gi)   +: 8],
                             block_in[8*(4*gi+1) +: 8],
                             block_in[8*(4*gi+2) +: 8],
                             block_in[8*(4*gi+3) +: 8]};
    end

    // Ring index, expansion and schedule word selection.
    always_comb begin
        idx      = rnd[IDX_W-1:0];
        direct   = (rnd < RND_W'(DEPTH));
        expanded = rotl(ring[idx] ^ ring[idx - IDX_W'(TAP_1)] ^
                        ring[idx - IDX_W'(TAP_2)] ^ ring[idx - IDX_W'(TAP_3)], 1);
        w_out    = direct ? ring[idx] : expanded;
    end

    // Fill on load, overwrite the oldest entry on expanding rounds.
    always_ff @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < DEPTH; i++) ring[i] <= load_w[i];
        end else if (step && !direct) begin
            ring[idx] <= expanded;
        end
    end

endmodule

// File: rtl/sha1_core.sv
// Iterative SHA-1 compression: one block per start, one round per clock,
// final feed-forward add, one-cycle done pulse with a held result.
// Assumes start is ignored while busy and that the caller handles padding.
module sha1_core
    import sha1_pkg::*;
#(
    parameter int ROUNDS      = 80,
    parameter int GROUP_LEN   = 20,
    parameter int SCHED_DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [5*WORD_W-1:0]           state_in,
    input  logic [SCHED_DEPTH*WORD_W-1:0] block_in,
    output logic                          busy,
    output logic                          done,
    output logic [5*WORD_W-1:0]           state_out
);

    localparam int RND_W = $clog2(ROUNDS);

    logic              busy_q, done_q, accept, last;
    logic [RND_W-1:0]  rnd_q;
    logic [1:0]        grp;
    hstate_t           work_q, chain_q, nxt, out_q;
    word_t             w;

    assign accept = start && !busy_q;
    assign last   = (rnd_q == RND_W'(ROUNDS - 1));

    // Group index from fixed round boundaries.
    always_comb begin
        if (rnd_q >= RND_W'(3 * GROUP_LEN))      grp = 2'd3;
        else if (rnd_q >= RND_W'(2 * GROUP_LEN)) grp = 2'd2;
        else if (rnd_q >= RND_W'(GROUP_LEN))     grp = 2'd1;
        else                                     grp = 2'd0;
    end

    sha1_sched #(
        .DEPTH (SCHED_DEPTH),
        .RND_W (RND_W)
    ) u_sched (
        .clk      (clk),
        .load     (accept),
        .step     (busy_q),
        .rnd      (rnd_q),
        .block_in (block_in),
        .w_out    (w)
    );

    sha1_round u_round (
        .cur (work_q),
        .w   (w),
        .grp (grp),
        .nxt (nxt)
    );

    // Control: round counter, busy, done and the held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rnd_q  <= '0;
            out_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                rnd_q  <= '0;
            end else if (busy_q) begin
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    rnd_q  <= '0;
                    out_q  <= add_state(chain_q, nxt);
                end else begin
                    rnd_q <= rnd_q + 1'b1;
                end
            end
        end
    end

    // Datapath: capture chaining value, then advance one round per cycle.
    always_ff @(posedge clk) begin
        if (accept) begin
            work_q  <= hstate_t'(state_in);
            chain_q <= hstate_t'(state_in);
        end else if (busy_q) begin
            work_q <= nxt;
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign state_out = out_q;

endmodule

// File: rtl/sha1_core_chk.sv
// Protocol checker for sha1_core, bound to every instance of it.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module sha1_core_chk #(
    parameter int ROUNDS = 80,
    parameter int RND_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [159:0]     state_out,
    input logic [RND_W-1:0] rnd
);

    assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && rnd == '0));

    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_round_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rnd < RND_W'(ROUNDS)));

    assert_done_excl_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_out_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(state_out));

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rnd != RND_W'(ROUNDS - 1)) |=> (busy && rnd == $past(rnd) + 1'b1));

endmodule

bind sha1_core sha1_core_chk #(
    .ROUNDS (ROUNDS),
    .RND_W  (RND_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .state_out (state_out),
    .rnd       (rnd_q)
);

// File: tb/sha1_core_tb.sv
module sha1_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ROUNDS     = 80;
    localparam logic [159:0] IV =
        160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [159:0] state_in = '0;
    logic [511:0] block_in = '0;
    logic         busy, done;
    logic [159:0] state_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 0;

    logic [159:0] exp_q[$];
    int           t0_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sha1_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .state_in  (state_in),
        .block_in  (block_in),
        .busy      (busy),
        .done      (done),
        .state_out (state_out)
    );

    // Reference model written straight from the requirements (full 80-word schedule).
    function automatic logic [159:0] ref_hash(input logic [159:0] st, input logic [511:0] blk);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, t, x;
        for (int i = 0; i < 16; i++)
            w[i] = {blk[32*i +: 8], blk[32*i+8 +: 8], blk[32*i+16 +: 8], blk[32*i+24 +: 8]};
        for (int i = 16; i < 80; i++) begin
            x = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
            w[i] = {x[30:0], x[31]};
        end
        {a, b, c, d, e} = st;
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);           k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                    k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d);  k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                    k = 32'hCA62C1D6; end
            t = {a[26:0], a[31:27]} + f + e + k + w[i];
            e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = t;
        end
        return {a + st[159:128], b + st[127:96], c + st[95:64], d + st[63:32], e + st[31:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [159:0] act,
                         input logic [159:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Driver: push the expected result, pulse start, wait for completion.
    task automatic run_block(input logic [159:0] st, input logic [511:0] blk,
                             input logic [159:0] expv);
        exp_q.push_back(expv);
        @(negedge clk);
        state_in = st;
        block_in = blk;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0_q.push_back(cyc);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop and compare on every done pulse; check latency (R2).
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected done", state_out, '0);
            end else begin
                logic [159:0] e;
                int t0;
                e  = exp_q.pop_front();
                t0 = t0_q.pop_front();
                check(state_out == e, "R4/R5/R6 digest", state_out, e);
                check(cyc - t0 == ROUNDS, "R2 latency", 160'(cyc - t0), 160'(ROUNDS));
                check(!busy, "R7 busy low at done", 160'(busy), 160'd0);
            end
        end
    end

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [511:0] blk, blk2, blk_b;
        logic [159:0] r, held;
        string s;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R1 busy", 160'(busy), 160'd0);
        check(done == 1'b0, "R1 done", 160'(done), 160'd0);
        check(state_out == '0, "R1 state_out", state_out, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: single-block "abc", byte k at [8k+7:8k]
        blk = '0;
        blk[0 +: 8] = 8'h61; blk[8 +: 8] = 8'h62; blk[16 +: 8] = 8'h63;
        blk[24 +: 8] = 8'h80; blk[63*8 +: 8] = 8'h18;
        r = 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D;
        check(ref_hash(IV, blk) == r, "R3 model abc", ref_hash(IV, blk), r);
        run_block(IV, blk, r);
        check(state_out == r, "R3 abc digest", state_out, r);

        // R7: output held, no further done
        held = state_out;
        repeat (30) @(negedge clk);
        check(state_out == held && !done && !busy, "R7 held", state_out, held);

        // R9/R5: two-block chained message
        s = "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq";
        blk = '0;
        for (int i = 0; i < 56; i++) blk[8*i +: 8] = s[i];
        blk[56*8 +: 8] = 8'h80;
        blk2 = '0;
        blk2[62*8 +: 8] = 8'h01; blk2[63*8 +: 8] = 8'hC0;
        run_block(IV, blk, ref_hash(IV, blk));
        r = 160'h84983E44_1C3BD26E_BAAE4AA1_F95129E5_E54670F1;
        run_block(state_out, blk2, r);
        check(state_out == r, "R9 chained digest", state_out, r);

        // R5/R6: random blocks under random chaining values
        for (int n = 0; n < 6; n++) begin
            logic [159:0] st;
            for (int i = 0; i < 16; i++) blk[32*i +: 32] = $urandom;
            for (int i = 0; i < 5; i++) st[32*i +: 32] = $urandom;
            run_block(st, blk, ref_hash(st, blk));
        end

        // R8: start while busy ignored
        for (int i = 0; i < 16; i++) blk[32*i +: 32] = $urandom;
        for (int i = 0; i < 16; i++) blk_b[32*i +: 32] = $urandom;
        exp_q.push_back(ref_hash(IV, blk));
        @(negedge clk);
        state_in = IV; block_in = blk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0_q.push_back(cyc);
        repeat (10) @(negedge clk);
        state_in = ~IV; block_in = blk_b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        r = ref_hash(IV, blk);
        check(state_out == r, "R8 result of first block", state_out, r);
        repeat (90) @(negedge clk);
        check(!busy && state_out == r, "R8 no restart", state_out, r);
        check(exp_q.size() == 0, "R8 queue drained", 160'(exp_q.size()), 160'd0);

        finish_run();
    end

endmodule